// File: doc/BRIEF.md
# Signed Integer to Single-Precision Converter

This block turns a 64-bit two's-complement integer into a single-precision floating-point value. It rounds under a 2-bit rounding-mode input. The operand is the low doubleword of a 128-bit source word, and the upper doubleword is ignored. The rounded single-precision value is returned re-encoded exactly in double-precision format in the low doubleword of a 128-bit result. The upper doubleword of the result is always driven to zero.

Along with the result, the block reports three things taken from the single-precision rounding step. The first is a flag that says rounding increased the magnitude. The second is a flag that says the result is inexact. The third is a one-hot 5-bit class code. It also returns the updated sticky inexact-exception bit and a pulse that sets the exception summary.

A facility-enable input gates the whole operation. When it is low, nothing is written and an unavailable-exception pulse is raised instead. All outputs are registered, one cycle after the request.

Top module: `sint_to_single_cvt`

## Requirements
- R1: The operand is src_i[63:0] read as a signed 64-bit integer; src_i[127:64] has no effect on any output.
- R2: rmode_i selects the rounding: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity; the result is the single-precision value so rounded.
- R3: res_o[63:0] is the double-precision encoding of the rounded value: sign in bit 63, exponent in bits 62:52 equal to the single-precision biased exponent plus 896, the 23-bit fraction in bits 51:29 and bits 28:0 zero.
- R4: On every write, res_o[127:64] is all zeros.
- R5: With fac_en_i low, a request writes nothing: res_we_o stays 0, res_o keeps its value, xx_o passes xx_i unchanged, fx_o is 0 and unavail_o pulses 1.
- R6: On a write, fr_o is 1 exactly when rounding increased the magnitude, and fi_o is 1 exactly when the rounded value differs from the integer.
- R7: On a write, xx_o is xx_i OR fi_o, so a previously set sticky bit is kept, and fx_o is 1 exactly when fi_o is 1.
- R8: class_o is 5'b00010 for +0, 5'b00100 for a positive normal and 5'b01000 for a negative normal.
- R9: Zero gives +0.0 with fr_o = fi_o = 0; -2^63 converts exactly; a mantissa carry from rounding moves the value into the next power of two.
- R10: Reset clears all outputs; res_we_o is 1 in the cycle after valid_i with fac_en_i high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request |
| fac_en_i | input | 1 | Facility enable |
| rmode_i | input | 2 | Rounding mode |
| src_i | input | 128 | Source word; low doubleword is the operand |
| xx_i | input | 1 | Current sticky inexact-exception bit |
| res_o | output | 128 | Result word |
| res_we_o | output | 1 | Result write strobe |
| fr_o | output | 1 | Fraction-rounded flag |
| fi_o | output | 1 | Fraction-inexact flag |
| class_o | output | 5 | Result class code |
| xx_o | output | 1 | Updated sticky inexact-exception bit |
| fx_o | output | 1 | Exception-summary set pulse |
| unavail_o | output | 1 | Facility-unavailable exception pulse |

## Verification
The hardest cases are exact ties at the guard position, with both parities of the kept least significant bit, and the rounding carry that overflows 24 mantissa bits into the next exponent. Uniform random integers almost never land on these. The stimulus therefore walks every power of two from 2^0 to 2^63 and adds offsets weighted at the guard bit: half an ulp, half plus one, one ulp less one, three halves, and all ones below the power. Each case is applied in both signs and all four rounding modes, with random upper doublewords and random sticky inputs.

// File: rtl/sxcvt_pkg.sv
`timescale 1ns/1ps
package sxcvt_pkg;
  localparam int INT_W    = 64;
  localparam int SP_FRAC  = 23;
  localparam int SP_EXP_W = 8;
  localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_FRAC  = 52;
  localparam int DP_EXP_W = 11;
  localparam int DP_BIAS  = (1 << (DP_EXP_W - 1)) - 1;
  localparam int REBIAS   = DP_BIAS - SP_BIAS;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_ZERO   = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_NEG    = 2'b11
  } rmode_e;

  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
endpackage

// File: rtl/sxcvt_lzc.sv
`timescale 1ns/1ps
module sxcvt_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  in_i,
  output logic [CW-1:0] cnt_o
);
  logic [W:0]    seen;
  logic [CW-1:0] cnt_at [W+1];

  assign seen[W]   = 1'b0;
  assign cnt_at[W] = CW'(W);

  // priority chain from MSB down: first set bit wins
  for (genvar i = W - 1; i >= 0; i--) begin : g_chain
    assign seen[i]   = seen[i+1] | in_i[i];
    assign cnt_at[i] = seen[i+1] ? cnt_at[i+1] : (in_i[i] ? CW'(W - 1 - i) : CW'(W));
  end

  assign cnt_o = cnt_at[0];
endmodule

// File: rtl/sxcvt_norm.sv
`timescale 1ns/1ps
module sxcvt_norm #(
  parameter int INT_W = 64,
  parameter int MAN_W = 24,
  parameter int CW    = $clog2(INT_W) + 1
) (
  input  logic [INT_W-1:0] src_i,
  output logic             neg_o,
  output logic             zero_o,
  output logic [MAN_W-1:0] mant_o,
  output logic             guard_o,
  output logic             sticky_o,
  output logic [CW-1:0]    exp_o
);
  localparam int GRD = INT_W - MAN_W - 1;

  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] norm;
  logic [CW-1:0]    lz;

  assign neg_o  = src_i[INT_W-1];
  assign mag    = neg_o ? (~src_i + INT_W'(1)) : src_i;
  assign zero_o = (mag == '0);

  sxcvt_lzc #(.W(INT_W), .CW(CW)) u_lzc (
    .in_i  (mag),
    .cnt_o (lz)
  );

  assign norm     = mag << lz;
  assign mant_o   = norm[INT_W-1 -: MAN_W];
  assign guard_o  = norm[GRD];
  assign sticky_o = |norm[GRD-1:0];
  assign exp_o    = CW'(INT_W - 1) - lz;
endmodule

// File: rtl/sxcvt_round.sv
`timescale 1ns/1ps
module sxcvt_round
  import sxcvt_pkg::*;
#(
  parameter int MAN_W = 24,
  parameter int CW    = 7
) (
  input  logic [MAN_W-1:0] mant_i,
  input  logic             guard_i,
  input  logic             sticky_i,
  input  logic             neg_i,
  input  logic [CW-1:0]    exp_i,
  input  logic [1:0]       rmode_i,
  output logic [MAN_W-2:0] frac_o,
  output logic [CW-1:0]    exp_o,
  output logic             fr_o,
  output logic             fi_o
);
  logic         inexact;
  logic         inc;
  logic [MAN_W:0] sum;

  assign inexact = guard_i | sticky_i;

  always_comb begin
    unique case (rmode_e'(rmode_i))
      RM_NEAR_EVEN: inc = guard_i & (sticky_i | mant_i[0]);
      RM_TO_ZERO:   inc = 1'b0;
      RM_TO_POS:    inc = ~neg_i & inexact;
      RM_TO_NEG:    inc = neg_i & inexact;
      default:      inc = 1'b0;
    endcase
  end

  // carry out leaves sum[MAN_W-2:0] zero, i.e. 1.0 of the next binade
  assign sum    = {1'b0, mant_i} + (MAN_W+1)'(inc);
  assign frac_o = sum[MAN_W-2:0];
  assign exp_o  = exp_i + CW'(sum[MAN_W]);
  assign fr_o   = inc;
  assign fi_o   = inexact;
endmodule

// File: rtl/sxcvt_pack.sv
`timescale 1ns/1ps
module sxcvt_pack
  import sxcvt_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic               neg_i,
  input  logic               zero_i,
  input  logic [SP_FRAC-1:0] frac_i,
  input  logic [CW-1:0]      exp_i,
  output logic [63:0]        dp_o,
  output logic [4:0]         cls_o
);
  localparam int PAD = DP_FRAC - SP_FRAC;

  logic [SP_EXP_W-1:0] sp_exp;
  logic [DP_EXP_W-1:0] dp_exp;

  assign sp_exp = SP_EXP_W'(exp_i) + SP_EXP_W'(SP_BIAS);
  assign dp_exp = DP_EXP_W'(sp_exp) + DP_EXP_W'(REBIAS);
  assign dp_o   = zero_i ? 64'd0 : {neg_i, dp_exp, frac_i, {PAD{1'b0}}};

  // class from the single-precision view: sign and zero only can occur
  always_comb begin
    if (zero_i)     cls_o = CLS_POS_ZERO;
    else if (neg_i) cls_o = CLS_NEG_NORM;
    else            cls_o = CLS_POS_NORM;
  end
endmodule

// File: rtl/sint_to_single_cvt.sv
`timescale 1ns/1ps
module sint_to_single_cvt
  import sxcvt_pkg::*;
#(
  parameter int SRC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fac_en_i,
  input  logic [1:0]       rmode_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic             xx_i,
  output logic [SRC_W-1:0] res_o,
  output logic             res_we_o,
  output logic             fr_o,
  output logic             fi_o,
  output logic [4:0]       class_o,
  output logic             xx_o,
  output logic             fx_o,
  output logic             unavail_o
);
  localparam int MAN_W = SP_FRAC + 1;
  localparam int CW    = $clog2(INT_W) + 1;
  localparam int PAD   = DP_FRAC - SP_FRAC;

  logic             unused_hi;
  logic             neg, zero, guard, sticky, fr_c, fi_c;
  logic [MAN_W-1:0] mant;
  logic [CW-1:0]    exp_n, exp_r;
  logic [SP_FRAC-1:0] frac;
  logic [63:0]      dp;
  logic [4:0]       cls;
  logic             do_wr, do_off;

  assign unused_hi = ^src_i[SRC_W-1:INT_W];

  sxcvt_norm #(.INT_W(INT_W), .MAN_W(MAN_W), .CW(CW)) u_norm (
    .src_i    (src_i[INT_W-1:0]),
    .neg_o    (neg),
    .zero_o   (zero),
    .mant_o   (mant),
    .guard_o  (guard),
    .sticky_o (sticky),
    .exp_o    (exp_n)
  );

  sxcvt_round #(.MAN_W(MAN_W), .CW(CW)) u_round (
    .mant_i   (mant),
    .guard_i  (guard),
    .sticky_i (sticky),
    .neg_i    (neg),
    .exp_i    (exp_n),
    .rmode_i  (rmode_i),
    .frac_o   (frac),
    .exp_o    (exp_r),
    .fr_o     (fr_c),
    .fi_o     (fi_c)
  );

  sxcvt_pack #(.CW(CW)) u_pack (
    .neg_i  (neg),
    .zero_i (zero),
    .frac_i (frac),
    .exp_i  (exp_r),
    .dp_o   (dp),
    .cls_o  (cls)
  );

  assign do_wr  = valid_i & fac_en_i;
  assign do_off = valid_i & ~fac_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      res_we_o  <= 1'b0;
      fr_o      <= 1'b0;
      fi_o      <= 1'b0;
      class_o   <= '0;
      xx_o      <= 1'b0;
      fx_o      <= 1'b0;
      unavail_o <= 1'b0;
    end else begin
      res_we_o  <= do_wr;
      unavail_o <= do_off;
      fx_o      <= do_wr & fi_c;
      if (do_wr) begin
        res_o   <= {{(SRC_W-64){1'b0}}, dp};
        fr_o    <= fr_c & ~zero;
        fi_o    <= fi_c & ~zero;
        class_o <= cls;
        xx_o    <= xx_i | fi_c;
      end else if (do_off) begin
        xx_o    <= xx_i;
      end
    end
  end

  a_r4_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (res_o[SRC_W-1:64] == '0));
  a_r3_tail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> (res_o[PAD-1:0] == '0));
  a_r5_off_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fac_en_i) |=> (!res_we_o && unavail_o));
  a_r5_off_keeps_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fac_en_i) |=> $stable(res_o));
  a_r6_fr_implies_fi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && fr_o) |-> fi_o);
  a_r7_sticky_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && xx_i) |=> xx_o);
  a_r7_fx_with_fi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_o |-> (xx_o && fi_o && res_we_o));
  a_r8_class_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> ($countones(class_o) == 1));
  a_r8_class_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_we_o && class_o == CLS_NEG_NORM) |-> res_o[63]);
  a_r9_zero_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fac_en_i && src_i[INT_W-1:0] == '0) |=> (res_o[63:0] == '0 && !fi_o && !fr_o));
  a_r10_we_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_we_o |-> !unavail_o);
endmodule

// File: tb/sint_to_single_cvt_tb_top.sv
`timescale 1ns/1ps
module sint_to_single_cvt_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         fac_en_i = 1'b0;
  logic [1:0]   rmode_i = 2'b00;
  logic [127:0] src_i = '0;
  logic         xx_i = 1'b0;
  logic [127:0] res_o;
  logic         res_we_o, fr_o, fi_o, xx_o, fx_o, unavail_o;
  logic [4:0]   class_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  sint_to_single_cvt dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fac_en_i(fac_en_i),
    .rmode_i(rmode_i), .src_i(src_i), .xx_i(xx_i), .res_o(res_o),
    .res_we_o(res_we_o), .fr_o(fr_o), .fi_o(fi_o), .class_o(class_o),
    .xx_o(xx_o), .fx_o(fx_o), .unavail_o(unavail_o)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // magnitude/remainder model, independent of the normalizer structure
  function automatic logic [63:0] ref_cvt(input logic [63:0] v, input logic [1:0] rm,
                                          output logic fr, output logic fi,
                                          output logic [4:0] cls);
    logic neg, up;
    logic [63:0] mag, m, rem, half;
    int p, sh;
    neg = v[63];
    mag = neg ? (64'd0 - v) : v;
    fr = 1'b0; fi = 1'b0; cls = 5'b00010;
    if (mag == 64'd0) return 64'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (mag[i]) p = i;
    if (p <= 23) begin
      m = mag << (23 - p); rem = 64'd0; half = 64'd0;
    end else begin
      sh = p - 23; m = mag >> sh; rem = mag - (m << sh); half = 64'd1 << (sh - 1);
    end
    fi = (rem != 64'd0);
    case (rm)
      2'b00:   up = (rem > half) || (fi && rem == half && m[0]);
      2'b01:   up = 1'b0;
      2'b10:   up = !neg && fi;
      default: up = neg && fi;
    endcase
    m = m + {63'd0, up};
    fr = up;
    if (m == (64'd1 << 24)) begin m = 64'd1 << 23; p++; end
    cls = neg ? 5'b01000 : 5'b00100;
    return {neg, 11'(p + 1023), m[22:0], 29'd0};
  endfunction

  // entered and left just after a falling edge
  task automatic apply(input logic [63:0] hi, input logic [63:0] v, input logic [1:0] rm,
                       input logic xx, input logic en);
    logic [63:0]  e;
    logic         efr, efi;
    logic [4:0]   ecls;
    logic [127:0] prev;
    prev = res_o;
    e = ref_cvt(v, rm, efr, efi, ecls);
    valid_i = 1'b1; fac_en_i = en; rmode_i = rm; src_i = {hi, v}; xx_i = xx;
    @(negedge clk_i);
    if (en) begin
      chk("R1 R2 R3 R9 result low", res_o[63:0], {64'd0, e});
      chk("R4 result high", res_o[127:64], '0);
      chk("R6 fr/fi", {126'd0, fr_o, fi_o}, {126'd0, efr, efi});
      chk("R7 xx/fx", {126'd0, xx_o, fx_o}, {126'd0, xx | efi, efi});
      chk("R8 class", {123'd0, class_o}, {123'd0, ecls});
      chk("R10 write strobe", {126'd0, res_we_o, unavail_o}, {126'd0, 2'b10});
    end else begin
      chk("R5 no write", {125'd0, res_we_o, unavail_o, fx_o}, {125'd0, 3'b010});
      chk("R5 result held", res_o, prev);
      chk("R5 xx passthrough", {127'd0, xx_o}, {127'd0, xx});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [63:0] base, h, v;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk("R10 reset outputs", {res_o[127:9], res_we_o, fr_o, fi_o, class_o, xx_o, fx_o, unavail_o},
        '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: named corners
    for (int rm = 0; rm < 4; rm++) begin
      apply($urandom, 64'd0, 2'(rm), 1'b0, 1'b1);
      apply($urandom, 64'h8000_0000_0000_0000, 2'(rm), 1'b0, 1'b1);
      apply($urandom, 64'h7FFF_FFFF_FFFF_FFFF, 2'(rm), 1'b1, 1'b1);
      apply($urandom, 64'hFFFF_FFFF_FFFF_FFFF, 2'(rm), 1'b0, 1'b1);
    end

    // R2 R6 R9: ties, near-ties and carries around every power of two
    for (int k = 0; k < 64; k++) begin
      for (int j = 0; j < 8; j++) begin
        for (int s = 0; s < 2; s++) begin
          for (int rm = 0; rm < 4; rm++) begin
            base = 64'd1 << k;
            h = (k >= 24) ? (64'd1 << (k - 24)) : 64'd0;
            case (j)
              0: v = base;
              1: v = base + h;
              2: v = base + h + 64'd1;
              3: v = base + 3 * h;
              4: v = base + 2 * h;
              5: v = base + 2 * h - 64'd1;
              6: v = base - 64'd1;
              default: v = base | (base >> 1) | h;
            endcase
            if (s == 1) v = 64'd0 - v;
            apply({$urandom, $urandom}, v, 2'(rm), 1'($urandom), 1'b1);
          end
        end
      end
    end

    // R1 R5: random operands, random high doubleword, facility toggling
    for (int n = 0; n < 3000; n++) begin
      v = {$urandom, $urandom} >> ($urandom % 64);
      if ($urandom % 2) v = 64'd0 - v;
      apply({$urandom, $urandom}, v, 2'($urandom), 1'($urandom), ($urandom % 8) != 0);
    end

    // R10: strobe drops once requests stop
    valid_i = 1'b0;
    @(negedge clk_i);
    chk("R10 idle strobe", {126'd0, res_we_o, unavail_o}, '0);
    report();
  end
endmodule